// File: doc/BRIEF.md
# Bufferless Deflection Torus Router Node

This block is one node of a two-dimensional torus network-on-chip in which every link runs one way only: flits travel east along the rows and south along the columns, and both rings wrap at the edge. Each packet is a single flit made of a destination coordinate pair and a 32-bit payload. The node takes a flit from its western neighbour, a flit from its northern neighbour and an optional flit from the local client. Each cycle it sends them out on two registered links, east and south. The south link also serves as the local delivery point: a flit addressed to this node leaves on it with an exit flag raised, and the next node down treats that slot as empty.

The node holds no buffers. Every flit that arrives in a cycle leaves in the next cycle on one of the two links. Routing is dimension-ordered: a flit goes east until its column matches, then south until its row matches, and then it exits. A flit arriving from the north always keeps the south link. A west flit that also wants to go south is therefore deflected east and travels once around its row before trying again. The client can inject only into a slot that in-flight traffic leaves free. A combinational ready tells the client that its flit was taken in that cycle.

Top module: `torus_router`

## Requirements
- R1: Each valid flit on the west input, each valid north flit and each accepted injection appears on exactly one output link in the next cycle. Flits are never dropped, duplicated or held.
- R2: A link word carries, from the most significant bit down: a valid bit, the destination column (log2 of the column count), the destination row (log2 of the row count) and a 32-bit payload. These fields pass through the node unchanged, and an idle link word is all zeros.
- R3: A west flit whose destination column differs from the node column leaves on the east link.
- R4: A flit whose destination column and row both equal the node's leaves on the south link with south_exit high, and south_exit is never high otherwise. A north input slot arriving with north_exit high counts as empty.
- R5: A valid north flit always takes the south link. When it does, a west flit that wants to go south or exit is deflected onto the east link.
- R6: inj_ready is high in a cycle exactly when inj_valid is high and the link the injected flit needs (east if its column differs, else south) is not taken by a west or north flit. An accepted flit leaves on that link.
- R7: Both links are registered. Outputs change only at a clock edge and show the routing result of the inputs present before that edge.
- R8: Synchronous active-high reset clears both links and south_exit.
- R9: A west flit whose column matches takes the south link when no valid north flit is present, with south_exit high if its row also matches.
- R10: In a 4x4 torus built from these nodes, each injected flit is delivered exactly once, at the node its coordinates name.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| west_in | input | FLIT_W | Link word from the western neighbour |
| north_in | input | FLIT_W | Link word from the northern neighbour |
| north_exit | input | 1 | Exit flag of the northern neighbour; marks north_in as consumed |
| inj_valid | input | 1 | Client offers a flit |
| inj_dx | input | XW | Destination column of the offered flit |
| inj_dy | input | YW | Destination row of the offered flit |
| inj_data | input | DATA_W | Payload of the offered flit |
| inj_ready | output | 1 | Offered flit accepted in this cycle |
| east_out | output | FLIT_W | Registered east link word |
| south_out | output | FLIT_W | Registered south link word; the delivered flit when south_exit is high |
| south_exit | output | 1 | Registered flag: south_out is addressed to this node |

## Verification
A wrong selection inside the node shows up one cycle later as a missing, doubled or misplaced flit on east_out or south_out, or as a wrongly raised exit flag. Any of these breaks the per-cycle count of flits in against flits out. A wrong ready decision shows at inj_ready in the same cycle, before the edge. In the assembled torus, one lost or misrouted flit shows as a delivery count other than one, or as a delivery at the wrong node, once the network has drained.

// File: rtl/torus_pkg.sv
package torus_pkg;

    localparam int TOR_COLS = 4;
    localparam int TOR_ROWS = 4;
    localparam int DATA_W   = 32;
    localparam int XW       = (TOR_COLS > 1) ? $clog2(TOR_COLS) : 1;
    localparam int YW       = (TOR_ROWS > 1) ? $clog2(TOR_ROWS) : 1;
    localparam int FLIT_W   = 1 + XW + YW + DATA_W;

    typedef struct packed {
        logic              vld;
        logic [XW-1:0]     dx;
        logic [YW-1:0]     dy;
        logic [DATA_W-1:0] data;
    } flit_t;

    typedef enum logic [1:0] {GO_NONE, GO_EAST, GO_SOUTH, GO_EXIT} heading_e;
    typedef enum logic [1:0] {SRC_NONE, SRC_WEST, SRC_NORTH, SRC_INJ} src_e;

    function automatic heading_e heading_of(flit_t f, logic [XW-1:0] hx, logic [YW-1:0] hy);
        if (!f.vld)          return GO_NONE;
        else if (f.dx != hx) return GO_EAST;
        else if (f.dy != hy) return GO_SOUTH;
        else                 return GO_EXIT;
    endfunction

endpackage

// File: rtl/route_arbiter.sv
module route_arbiter
    import torus_pkg::*;
#(
    parameter int NODE_X = 0,
    parameter int NODE_Y = 0
) (
    input  flit_t w_f,
    input  flit_t n_f,
    input  flit_t i_f,
    output src_e  east_sel,
    output src_e  south_sel,
    output logic  south_home,
    output logic  inj_take
);
    localparam logic [XW-1:0] HX = XW'(NODE_X);
    localparam logic [YW-1:0] HY = YW'(NODE_Y);

    heading_e w_go, n_go, i_go;

    assign w_go = heading_of(w_f, HX, HY);
    assign n_go = heading_of(n_f, HX, HY);
    assign i_go = heading_of(i_f, HX, HY);

    always_comb begin
        east_sel   = SRC_NONE;
        south_sel  = SRC_NONE;
        south_home = 1'b0;
        inj_take   = 1'b0;
        // column ring traffic owns the south link
        if (n_f.vld) begin
            south_sel  = SRC_NORTH;
            south_home = (n_go == GO_EXIT);
        end else if (w_f.vld && w_go != GO_EAST) begin
            south_sel  = SRC_WEST;
            south_home = (w_go == GO_EXIT);
        end
        // west flit that did not win south rides on east (straight or deflected)
        if (w_f.vld && south_sel != SRC_WEST) begin
            east_sel = SRC_WEST;
        end
        // client fills only a slot left free
        if (i_f.vld) begin
            if (i_go == GO_EAST) begin
                if (east_sel == SRC_NONE) begin
                    east_sel = SRC_INJ;
                    inj_take = 1'b1;
                end
            end else if (south_sel == SRC_NONE) begin
                south_sel  = SRC_INJ;
                south_home = (i_go == GO_EXIT);
                inj_take   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/link_reg.sv
module link_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/torus_router.sv
module torus_router
    import torus_pkg::*;
#(
    parameter int NODE_X = 0,
    parameter int NODE_Y = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLIT_W-1:0] west_in,
    input  logic [FLIT_W-1:0] north_in,
    input  logic              north_exit,
    input  logic              inj_valid,
    input  logic [XW-1:0]     inj_dx,
    input  logic [YW-1:0]     inj_dy,
    input  logic [DATA_W-1:0] inj_data,
    output logic              inj_ready,
    output logic [FLIT_W-1:0] east_out,
    output logic [FLIT_W-1:0] south_out,
    output logic              south_exit
);
    localparam logic [XW-1:0] HX = XW'(NODE_X);
    localparam logic [YW-1:0] HY = YW'(NODE_Y);

    flit_t w_f, n_f, i_f, e_nx, s_nx, e_f, s_f;
    src_e  east_sel, south_sel;
    logic  south_home, inj_take;
    logic [FLIT_W:0] s_q;

    assign w_f = flit_t'(west_in);

    always_comb begin
        n_f     = flit_t'(north_in);
        n_f.vld = n_f.vld & ~north_exit;   // delivered slot is free again
    end

    assign i_f = '{vld: inj_valid, dx: inj_dx, dy: inj_dy, data: inj_data};

    route_arbiter #(.NODE_X(NODE_X), .NODE_Y(NODE_Y)) u_arb (
        .w_f        (w_f),
        .n_f        (n_f),
        .i_f        (i_f),
        .east_sel   (east_sel),
        .south_sel  (south_sel),
        .south_home (south_home),
        .inj_take   (inj_take)
    );

    always_comb begin
        case (east_sel)
            SRC_WEST: e_nx = w_f;
            SRC_INJ:  e_nx = i_f;
            default:  e_nx = '0;
        endcase
        case (south_sel)
            SRC_WEST:  s_nx = w_f;
            SRC_NORTH: s_nx = n_f;
            SRC_INJ:   s_nx = i_f;
            default:   s_nx = '0;
        endcase
    end

    link_reg #(.W(FLIT_W)) u_east (
        .clk (clk),
        .rst (rst),
        .d   (e_nx),
        .q   (east_out)
    );

    link_reg #(.W(FLIT_W + 1)) u_south (
        .clk (clk),
        .rst (rst),
        .d   ({s_nx, south_home}),
        .q   (s_q)
    );

    assign south_out  = s_q[FLIT_W:1];
    assign south_exit = s_q[0];
    assign inj_ready  = inj_take;

    assign e_f = flit_t'(east_out);
    assign s_f = flit_t'(south_out);

    AST_FLIT_CONSERVE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones({e_f.vld, s_f.vld}) ==
                  $past($countones({w_f.vld, n_f.vld, inj_take})))); // R1

    AST_ONE_SEAT: assert property (@(posedge clk) disable iff (rst)
        !(east_sel == south_sel && east_sel != SRC_NONE)); // R1

    AST_NORTH_KEEPS_SOUTH: assert property (@(posedge clk) disable iff (rst)
        n_f.vld |=> (s_f.vld && s_f.data == $past(n_f.data) && s_f.dy == $past(n_f.dy))); // R5

    AST_EXIT_HOME: assert property (@(posedge clk) disable iff (rst)
        south_exit |-> (s_f.vld && s_f.dx == HX && s_f.dy == HY)); // R4

    AST_INJ_YIELDS: assert property (@(posedge clk) disable iff (rst)
        inj_ready |-> (inj_valid && !(w_f.vld && n_f.vld))); // R6

endmodule

// File: tb/torus_router_test.sv
module torus_router_test;
    import torus_pkg::*;

    localparam int FW = FLIT_W;
    localparam int NN = TOR_COLS * TOR_ROWS;
    localparam int NF = 20;
    localparam int UX = 1;
    localparam int UY = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // ---------------- single node under test ----------------
    logic [FW-1:0]     west_in = '0, north_in = '0;
    logic              north_exit = 1'b0, inj_valid = 1'b0;
    logic [XW-1:0]     inj_dx = '0;
    logic [YW-1:0]     inj_dy = '0;
    logic [DATA_W-1:0] inj_data = '0;
    logic              inj_ready, south_exit;
    logic [FW-1:0]     east_out, south_out;

    torus_router #(.NODE_X(UX), .NODE_Y(UY)) uut (
        .clk(clk), .rst(rst), .west_in(west_in), .north_in(north_in),
        .north_exit(north_exit), .inj_valid(inj_valid), .inj_dx(inj_dx),
        .inj_dy(inj_dy), .inj_data(inj_data), .inj_ready(inj_ready),
        .east_out(east_out), .south_out(south_out), .south_exit(south_exit)
    );

    // ---------------- 4x4 torus ----------------
    logic [FW-1:0]     e_lnk [NN];
    logic [FW-1:0]     s_lnk [NN];
    logic              s_ex  [NN];
    logic              t_v   [NN];
    logic [XW-1:0]     t_dx  [NN];
    logic [YW-1:0]     t_dy  [NN];
    logic [DATA_W-1:0] t_d   [NN];
    logic              t_rdy [NN];

    for (genvar gy = 0; gy < TOR_ROWS; gy++) begin : g_row
        for (genvar gx = 0; gx < TOR_COLS; gx++) begin : g_col
            localparam int ME = gy * TOR_COLS + gx;
            localparam int WN = gy * TOR_COLS + (gx + TOR_COLS - 1) % TOR_COLS;
            localparam int NO = ((gy + TOR_ROWS - 1) % TOR_ROWS) * TOR_COLS + gx;
            torus_router #(.NODE_X(gx), .NODE_Y(gy)) net (
                .clk(clk), .rst(rst), .west_in(e_lnk[WN]), .north_in(s_lnk[NO]),
                .north_exit(s_ex[NO]), .inj_valid(t_v[ME]), .inj_dx(t_dx[ME]),
                .inj_dy(t_dy[ME]), .inj_data(t_d[ME]), .inj_ready(t_rdy[ME]),
                .east_out(e_lnk[ME]), .south_out(s_lnk[ME]), .south_exit(s_ex[ME])
            );
        end
    end

    function automatic logic [FW-1:0] mk(bit v, int dx, int dy, logic [DATA_W-1:0] d);
        return {v, XW'(dx), YW'(dy), d};
    endfunction

    function automatic int dest_of(int src, int k);
        return (src * 5 + k * 7 + 3) % NN;
    endfunction

    task automatic chk(bit ok, string tag, logic [FW:0] act, logic [FW:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    logic [FW-1:0] prev_e = '0, prev_s = '0;
    bit            prev_x = 1'b0;

    // one cycle of the single-node sweep; entered just after a falling edge
    task automatic step(int wi, int ni, int ii);
        bit wv, nv, iv, acc, sw, ex;
        int wgo, igo;
        logic [FW-1:0] wf, nf, ifl, ee, es;
        wv  = (wi < 16);
        nv  = (ni < 4);
        iv  = (ii < 16);
        wf  = mk(wv, wi % 4, (wi / 4) % 4, 32'hA000_0000 + 32'(wi * 4096 + ni * 64 + ii));
        nf  = mk(ni < 8, UX, ni % 4, 32'hB000_0000 + 32'(wi * 4096 + ni * 64 + ii));
        ifl = mk(1'b1, ii % 4, (ii / 4) % 4, 32'hC000_0000 + 32'(wi * 4096 + ni * 64 + ii));
        wgo = (wi % 4 != UX) ? 0 : (((wi / 4) % 4 != UY) ? 1 : 2);
        igo = (ii % 4 != UX) ? 0 : (((ii / 4) % 4 != UY) ? 1 : 2);
        ee = '0; es = '0; ex = 1'b0; sw = 1'b0;
        if (nv) begin
            es = nf; ex = (ni % 4 == UY);
        end else if (wv && wgo != 0) begin
            es = wf; ex = (wgo == 2); sw = 1'b1;
        end
        if (wv && !sw) ee = wf;
        acc = iv && ((igo == 0) ? !ee[FW-1] : !es[FW-1]);
        if (acc) begin
            if (igo == 0) ee = ifl;
            else begin es = ifl; ex = (igo == 2); end
        end
        west_in    = wf;
        north_in   = nf;
        north_exit = (ni >= 4 && ni < 8);
        inj_valid  = iv;
        inj_dx     = ifl[FW-2 -: XW];
        inj_dy     = ifl[DATA_W +: YW];
        inj_data   = ifl[DATA_W-1:0];
        #1;
        chk(inj_ready == acc, "R6 ready", {{FW{1'b0}}, inj_ready}, {{FW{1'b0}}, acc});
        chk(east_out == prev_e && south_out == prev_s && south_exit == prev_x,
            "R7 held until edge", {east_out, south_exit}, {prev_e, prev_x});
        @(negedge clk);
        chk(east_out == ee, (nv && wv && wgo != 0) ? "R5 deflect east" : "R2 R3 east",
            {1'b0, east_out}, {1'b0, ee});
        chk(south_out == es, nv ? "R5 north south" : "R2 R9 south",
            {1'b0, south_out}, {1'b0, es});
        chk(south_exit == ex, "R4 exit", {{FW{1'b0}}, south_exit}, {{FW{1'b0}}, ex});
        chk(32'($countones({east_out[FW-1], south_out[FW-1]})) == 32'(int'(wv) + int'(nv) + int'(acc)),
            "R1 count", {{(FW-1){1'b0}}, east_out[FW-1], south_out[FW-1]},
            (FW+1)'(int'(wv) + int'(nv) + int'(acc)));
        prev_e = ee; prev_s = es; prev_x = ex;
    endtask

    // delivery scoreboard
    int  got [NN][NF];
    int  misroute = 0;
    bit  mon_on = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            for (int n = 0; n < NN; n++) begin
                if (s_ex[n] && s_lnk[n][FW-1]) begin
                    int src, k;
                    src = int'(s_lnk[n][DATA_W-1:8]);
                    k   = int'(s_lnk[n][7:0]);
                    if (src < NN && k < NF) begin
                        got[src][k]++;
                        if (dest_of(src, k) != n) misroute++;
                    end else misroute++;
                end
            end
        end
    end

    initial begin
        repeat (400000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ptr [NN];
        bit acc [NN];
        bit done;
        for (int n = 0; n < NN; n++) begin
            ptr[n] = 0; acc[n] = 1'b0;
            t_v[n] = 1'b0; t_dx[n] = '0; t_dy[n] = '0; t_d[n] = '0;
            for (int k = 0; k < NF; k++) got[n][k] = 0;
        end
        west_in  = mk(1'b1, 2, 2, 32'h1234_5678);
        inj_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R8: reset clears the links even with traffic present
        chk(east_out == '0 && south_out == '0 && south_exit == 1'b0, "R8 reset",
            {east_out, south_exit}, '0);
        rst = 1'b0;

        for (int wi = 0; wi < 17; wi++)
            for (int ni = 0; ni < 9; ni++)
                for (int ii = 0; ii < 17; ii++)
                    step(wi, ni, ii);

        // torus traffic, R10
        mon_on = 1'b1;
        done = 1'b0;
        for (int c = 0; c < 20000 && !done; c++) begin
            @(negedge clk);
            done = 1'b1;
            for (int n = 0; n < NN; n++) begin
                if (acc[n]) ptr[n]++;
                acc[n] = 1'b0;
                if (ptr[n] < NF) begin
                    done    = 1'b0;
                    t_v[n]  = 1'b1;
                    t_dx[n] = XW'(dest_of(n, ptr[n]) % TOR_COLS);
                    t_dy[n] = YW'(dest_of(n, ptr[n]) / TOR_COLS);
                    t_d[n]  = DATA_W'(n * 256 + ptr[n]);
                end else t_v[n] = 1'b0;
            end
            #2;
            for (int n = 0; n < NN; n++) acc[n] = t_v[n] && t_rdy[n];
        end
        repeat (300) @(negedge clk);
        for (int n = 0; n < NN; n++)
            for (int k = 0; k < NF; k++)
                chk(got[n][k] == 1, "R10 delivered once", (FW+1)'(got[n][k]), (FW+1)'(1));
        chk(misroute == 0, "R10 right node", (FW+1)'(misroute), '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule